// File: doc/BRIEF.md
# Video memory address sequencer

This block generates the addresses at which a raster display fetches its pixel bytes and colour bytes from video RAM, and it shares that RAM with a CPU by time slots. A 13-bit position counter advances by one on each fetch step strobe. In a video slot, the current count is turned into one of two addresses. When the phase input is high it is a bitmap byte address. When it is low it is the address of the attribute that colours the 8x8 cell containing that byte.

In a CPU slot, the CPU address, write data and write strobe drive the RAM instead, and read data returns to the CPU. The RAM address is registered, so it stays stable for the whole slot that follows. Requesting both slots at once is a usage error. The block flags it and makes no RAM access.

Top module: `vid_addr_seq`

## Requirements
- R1: After reset, pos_o, ram_addr_o, ram_cs_o, ram_we_o, fetch_bmp_o and fetch_attr_o are all zero.
- R2: When step_i is high and frame_start_i is low, pos_o increases by one at the next clock edge. When step_i is low, pos_o holds.
- R3: A step taken while pos_o is 6143 returns pos_o to 0.
- R4: When frame_start_i is high, pos_o is 0 after the next edge. This takes priority over step_i.
- R5: A video slot (vid_en_i=1, cpu_en_i=0) with phase_bmp_i=1 gives ram_addr_o = pos, ram_cs_o=1 and fetch_bmp_o=1 one cycle later. Here pos is the value pos_o had in the slot cycle.
- R6: A video slot with phase_bmp_i=0 gives ram_addr_o = 6144 + (pos/256)*32 + (pos mod 32), ram_cs_o=1 and fetch_attr_o=1 one cycle later.
- R7: A CPU slot (cpu_en_i=1, vid_en_i=0) gives ram_addr_o = cpu_addr_i, ram_wdata_o = cpu_wdata_i, ram_we_o = cpu_we_i and ram_cs_o=1 one cycle later. Both fetch flags are 0.
- R8: cpu_rdata_o equals ram_rdata_i while ram_cs_o is serving a CPU slot, and is 0 otherwise.
- R9: When neither enable is high, ram_cs_o and ram_we_o are 0 one cycle later and ram_addr_o keeps its value.
- R10: When both enables are high, bus_conflict_o is 1 in that same cycle. One cycle later ram_cs_o and ram_we_o are 0 and ram_addr_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start_i | input | 1 | Clears the position counter |
| step_i | input | 1 | Fetch step strobe, advances the counter |
| phase_bmp_i | input | 1 | 1 selects the bitmap map, 0 selects the attribute map |
| vid_en_i | input | 1 | Video access slot |
| cpu_en_i | input | 1 | CPU access slot |
| cpu_addr_i | input | 13 | CPU RAM address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_rdata_o | output | 8 | Read data returned to the CPU |
| ram_rdata_i | input | 8 | Data from the RAM |
| ram_addr_o | output | 13 | Registered RAM address |
| ram_wdata_o | output | 8 | Registered RAM write data |
| ram_we_o | output | 1 | Registered RAM write enable |
| ram_cs_o | output | 1 | Registered RAM select |
| fetch_bmp_o | output | 1 | Current slot is a bitmap fetch |
| fetch_attr_o | output | 1 | Current slot is an attribute fetch |
| pos_o | output | 13 | Position counter value |
| bus_conflict_o | output | 1 | Both access enables are high |

## Verification
Every registered result is due one edge after the cycle that presents its stimulus. This covers the counter, the RAM address and controls, and the fetch flags. bus_conflict_o and cpu_rdata_o are combinational and are valid in the cycle itself. The bench drives inputs on the falling edge and then passes one rising edge. It samples registered outputs on the following falling edge. For the video map checks, it records pos_o before the edge, because the address is built from the pre-step count.

// File: rtl/vid_addr_seq.sv
module vid_addr_seq #(
  parameter int AW          = 13,
  parameter int DW          = 8,
  parameter int COL_LOG     = 5,
  parameter int ROW_LOG     = 3,
  parameter int FRAME_BYTES = 6144,
  parameter int ATTR_BASE   = 6144
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start_i,
  input  logic          step_i,
  input  logic          phase_bmp_i,
  input  logic          vid_en_i,
  input  logic          cpu_en_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic          cpu_we_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic [DW-1:0] ram_rdata_i,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  output logic          ram_we_o,
  output logic          ram_cs_o,
  output logic          fetch_bmp_o,
  output logic          fetch_attr_o,
  output logic [AW-1:0] pos_o,
  output logic          bus_conflict_o
);
  localparam int            LINE_LOG = COL_LOG + ROW_LOG;
  localparam logic [AW-1:0] LAST     = AW'(FRAME_BYTES - 1);
  localparam logic [AW-1:0] COL_MASK = AW'((1 << COL_LOG) - 1);
  localparam logic [AW-1:0] ABASE    = AW'(ATTR_BASE);

  logic [AW-1:0] pos_q;
  logic [AW-1:0] bmp_addr, attr_addr, vid_addr;
  logic          vid_slot, cpu_slot, cpu_q;

  assign vid_slot       = vid_en_i & ~cpu_en_i;
  assign cpu_slot       = cpu_en_i & ~vid_en_i;
  assign bus_conflict_o = vid_en_i & cpu_en_i;

  assign bmp_addr  = pos_q;
  assign attr_addr = ABASE + ((pos_q >> LINE_LOG) << COL_LOG) + (pos_q & COL_MASK);
  assign vid_addr  = phase_bmp_i ? bmp_addr : attr_addr;

  always_ff @(posedge clk) begin
    if (!rst_n)
      pos_q <= '0;
    else if (frame_start_i)
      pos_q <= '0;
    else if (step_i)
      pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_addr_o   <= '0;
      ram_wdata_o  <= '0;
      ram_we_o     <= 1'b0;
      ram_cs_o     <= 1'b0;
      fetch_bmp_o  <= 1'b0;
      fetch_attr_o <= 1'b0;
      cpu_q        <= 1'b0;
    end else begin
      ram_cs_o     <= vid_slot | cpu_slot;
      ram_we_o     <= cpu_slot & cpu_we_i;
      fetch_bmp_o  <= vid_slot & phase_bmp_i;
      fetch_attr_o <= vid_slot & ~phase_bmp_i;
      cpu_q        <= cpu_slot;
      if (cpu_slot) begin
        ram_addr_o  <= cpu_addr_i;
        ram_wdata_o <= cpu_wdata_i;
      end else if (vid_slot) begin
        ram_addr_o  <= vid_addr;
      end
    end
  end

  assign cpu_rdata_o = cpu_q ? ram_rdata_i : '0;
  assign pos_o       = pos_q;
endmodule

// File: rtl/vid_addr_seq_chk.sv
module vid_addr_seq_chk #(
  parameter int AW   = 13,
  parameter int LAST = 6143
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start_i,
  input logic          step_i,
  input logic          vid_en_i,
  input logic          cpu_en_i,
  input logic [AW-1:0] cpu_addr_i,
  input logic [AW-1:0] ram_addr_o,
  input logic          ram_cs_o,
  input logic          ram_we_o,
  input logic          fetch_bmp_o,
  input logic          fetch_attr_o,
  input logic [AW-1:0] pos_o
);
  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !frame_start_i && pos_o != AW'(LAST)) |=> pos_o == $past(pos_o) + 1'b1);
  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !frame_start_i && pos_o == AW'(LAST)) |=> pos_o == '0);
  // R4
  frame_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> pos_o == '0);
  // R7
  cpu_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en_i && !vid_en_i) |=> (ram_addr_o == $past(cpu_addr_i) && ram_cs_o && !fetch_bmp_o && !fetch_attr_o));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_en_i && !vid_en_i) |=> (!ram_cs_o && !ram_we_o && $stable(ram_addr_o)));
  // R10
  conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en_i && vid_en_i) |=> (!ram_cs_o && !ram_we_o && $stable(ram_addr_o)));
  // R5
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_bmp_o, fetch_attr_o}));
endmodule

bind vid_addr_seq vid_addr_seq_chk #(.AW(AW), .LAST(FRAME_BYTES - 1)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i), .step_i(step_i),
  .vid_en_i(vid_en_i), .cpu_en_i(cpu_en_i), .cpu_addr_i(cpu_addr_i),
  .ram_addr_o(ram_addr_o), .ram_cs_o(ram_cs_o), .ram_we_o(ram_we_o),
  .fetch_bmp_o(fetch_bmp_o), .fetch_attr_o(fetch_attr_o), .pos_o(pos_o)
);

// File: tb/vid_addr_seq_tb.sv
`timescale 1ns/1ps
module vid_addr_seq_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        frame_start_i = 0, step_i = 0, phase_bmp_i = 0;
  logic        vid_en_i = 0, cpu_en_i = 0, cpu_we_i = 0;
  logic [12:0] cpu_addr_i = 0;
  logic [7:0]  cpu_wdata_i = 0, ram_rdata_i = 0;
  logic [7:0]  cpu_rdata_o, ram_wdata_o;
  logic [12:0] ram_addr_o, pos_o;
  logic        ram_we_o, ram_cs_o, fetch_bmp_o, fetch_attr_o, bus_conflict_o;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  vid_addr_seq dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle_in();
    step_i = 0; frame_start_i = 0; vid_en_i = 0; cpu_en_i = 0; cpu_we_i = 0;
  endtask

  function automatic int attr_of(input int p);
    return 6144 + (p / 256) * 32 + (p % 32);
  endfunction

  task automatic t_reset();
    chk("R1 pos", pos_o, 0); chk("R1 addr", ram_addr_o, 0);
    chk("R1 cs", ram_cs_o, 0); chk("R1 we", ram_we_o, 0);
    chk("R1 flags", {fetch_bmp_o, fetch_attr_o}, 0);
  endtask

  task automatic t_step();
    int p0 = pos_o;
    step_i = 1; tick(); tick(); tick();
    chk("R2 three steps", pos_o, p0 + 3);
    step_i = 0; tick(); tick();
    chk("R2 hold", pos_o, p0 + 3);
  endtask

  task automatic t_wrap();
    frame_start_i = 1; tick(); frame_start_i = 0;
    step_i = 1;
    for (int i = 0; i < 6143; i++) tick();
    chk("R3 at last", pos_o, 6143);
    tick();
    chk("R3 wrapped", pos_o, 0);
    tick();
    chk("R3 after wrap", pos_o, 1);
    step_i = 0;
  endtask

  task automatic t_frame();
    step_i = 1; tick(); tick(); tick(); tick();
    frame_start_i = 1; tick();
    chk("R4 clear over step", pos_o, 0);
    idle_in(); tick();
    chk("R4 stays", pos_o, 0);
  endtask

  task automatic t_bitmap();
    int p;
    step_i = 1;
    for (int i = 0; i < 300; i++) tick();
    p = pos_o;
    vid_en_i = 1; phase_bmp_i = 1; tick();
    chk("R5 addr", ram_addr_o, p); chk("R5 cs", ram_cs_o, 1);
    chk("R5 flag", fetch_bmp_o, 1); chk("R5 attr flag", fetch_attr_o, 0);
    idle_in();
  endtask

  task automatic t_attr();
    int p;
    step_i = 1;
    for (int i = 0; i < 1000; i++) tick();
    p = pos_o;
    vid_en_i = 1; phase_bmp_i = 0; step_i = 1; tick();
    chk("R6 addr", ram_addr_o, attr_of(p)); chk("R6 flag", fetch_attr_o, 1);
    chk("R6 bmp flag", fetch_bmp_o, 0);
    p = pos_o; tick();
    chk("R6 addr next", ram_addr_o, attr_of(p));
    idle_in();
  endtask

  task automatic t_cpu();
    cpu_en_i = 1; cpu_addr_i = 13'h1abc; cpu_wdata_i = 8'h5a; cpu_we_i = 1; tick();
    chk("R7 addr", ram_addr_o, 'h1abc); chk("R7 wdata", ram_wdata_o, 'h5a);
    chk("R7 we", ram_we_o, 1); chk("R7 cs", ram_cs_o, 1);
    chk("R7 flags", {fetch_bmp_o, fetch_attr_o}, 0);
    cpu_we_i = 0; cpu_addr_i = 13'h0042; tick();
    chk("R7 read we", ram_we_o, 0); chk("R7 read addr", ram_addr_o, 'h42);
    ram_rdata_i = 8'hc3; #0.1;
    chk("R8 rdata", cpu_rdata_o, 'hc3);
    idle_in(); tick(); #0.1;
    chk("R8 rdata gated", cpu_rdata_o, 0);
    vid_en_i = 1; phase_bmp_i = 1; tick(); #0.1;
    chk("R8 gated in video", cpu_rdata_o, 0);
    idle_in();
  endtask

  task automatic t_idle();
    int a;
    cpu_en_i = 1; cpu_addr_i = 13'h0777; tick(); idle_in();
    a = ram_addr_o;
    tick(); tick();
    chk("R9 addr held", ram_addr_o, a); chk("R9 cs", ram_cs_o, 0); chk("R9 we", ram_we_o, 0);
  endtask

  task automatic t_conflict();
    int a = ram_addr_o;
    vid_en_i = 1; cpu_en_i = 1; cpu_we_i = 1; cpu_addr_i = 13'h0123; #0.1;
    chk("R10 flag", bus_conflict_o, 1);
    tick();
    chk("R10 cs", ram_cs_o, 0); chk("R10 we", ram_we_o, 0); chk("R10 addr", ram_addr_o, a);
    idle_in(); #0.1;
    chk("R10 flag clear", bus_conflict_o, 0);
  endtask

  initial begin
    tick(); tick(); rst_n = 1; tick();
    t_reset(); t_step(); t_wrap(); t_frame(); t_bitmap(); t_attr();
    t_cpu(); t_idle(); t_conflict();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule